// File: doc/BRIEF.md
# Hibernate State Controller

This block moves a system between normal operation and a low-power hibernate state under the control of one register bit. While the system hibernates, three board-level pins take programmed levels instead of their normal values: the active-low system reset, the active-low memory reset and the active-low interrupt line. Each pin has its own control bit, so each can be held asserted, held deasserted or, for the interrupt, left to follow its normal source.

When software clears the hibernate bit, the block leaves hibernate along one of two paths. It can go straight back to normal operation, or it can first raise a request to an external startup sequencer and wait for that sequencer's done input. On the way out it can also issue a one-clock pulse that resets the registers in the rest of the chip. Both exit actions are chosen independently. Outside hibernate, the three pins pass through from the logic that normally drives them, one register stage late.

Top module: `hib_ctrl`

## Requirements
- R1: After a synchronous reset, `state` is 0 (active), `startup_req` and `reg_rst_pulse` are 0, all three pin outputs are 1, and all control bits are 0.
- R2: A write with `wr_en` high and `wr_addr` equal to `CFG_ADDR` loads the control bits from `wr_data`: bit 0 hibernate request, bit 1 exit through startup, bit 2 keep registers on exit, bit 3 reset-pin level, bit 4 interrupt quiet, bit 5 memory-reset-pin level. A write to any other address changes nothing.
- R3: The `state` output uses code 0 for active, 1 for hibernate and 2 for startup. In the active state, a hibernate request bit of 1 moves `state` to 1 on the clock edge after the register was loaded.
- R4: In hibernate, once the request bit reads 0 and bit 1 is 0, `state` returns to 0 on the next edge.
- R5: In hibernate, once the request bit reads 0 and bit 1 is 1, `state` moves to 2; `startup_req` is 1 exactly while `state` is 2; `state` stays 2 until `startup_done` is sampled high, then becomes 0.
- R6: On the edge that leaves hibernate, `reg_rst_pulse` goes high for exactly one cycle if bit 2 is 0, and stays low if bit 2 is 1. It never rises on any other edge.
- R7: One cycle after `state` is 1, `rst_n_out` equals bit 3 (0 holds reset asserted, 1 holds it released), whatever `rst_n_in` is.
- R8: One cycle after `state` is 1, `irq_n_out` is 1 when bit 4 is 1, and follows `irq_n_in` one cycle late when bit 4 is 0.
- R9: One cycle after `state` is 1, `memrst_n_out` equals bit 5, whatever `memrst_n_in` is.
- R10: One cycle after `state` is not 1, each pin output equals its input from the previous cycle.
- R11: `startup_done` has no effect outside the startup state, and a hibernate request loaded during startup takes effect only after the controller has returned to active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| startup_done | input | 1 | External startup sequencer finished |
| rst_n_in | input | 1 | Normal value of the active-low system reset pin |
| irq_n_in | input | 1 | Normal value of the active-low interrupt pin |
| memrst_n_in | input | 1 | Normal value of the active-low memory reset pin |
| state | output | 2 | Current state: 0 active, 1 hibernate, 2 startup |
| startup_req | output | 1 | Request to the external startup sequencer |
| reg_rst_pulse | output | 1 | One-cycle register reset on hibernate exit |
| rst_n_out | output | 1 | System reset pin value |
| irq_n_out | output | 1 | Interrupt pin value |
| memrst_n_out | output | 1 | Memory reset pin value |

## Verification
The bench builds the block with a 3-bit address and the control register at address 3, which makes foreign addresses few enough to try several of them alongside the real one. With the six control bits, the five mode bits form only 32 combinations, so every combination of pin levels and exit path is put through a full enter-and-leave cycle, with the expected pin levels, pulse and state sequence derived from the bits of the loop index.

// File: rtl/hib_pkg.sv
package hib_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_HIB     = 2'd1,
    ST_STARTUP = 2'd2
  } hib_state_e;

  // Control word, bit 0 first from the right.
  typedef struct packed {
    logic memrst_level;
    logic irq_quiet;
    logic rst_level;
    logic keep_regs;
    logic via_startup;
    logic hib_req;
  } hib_cfg_t;

  localparam int CFG_BITS = $bits(hib_cfg_t);

endpackage

// File: rtl/hib_cfg_regs.sv
module hib_cfg_regs
  import hib_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int CFG_ADDR = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output hib_cfg_t          cfg_o
);

  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(CFG_ADDR);

  hib_cfg_t cfg_q;
  logic     hit;

  assign hit = wr_en && (wr_addr == SEL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (hit) begin
      cfg_q <= hib_cfg_t'(wr_data[CFG_BITS-1:0]);
    end
  end

  assign cfg_o = cfg_q;

  // R2: foreign addresses leave the control bits untouched
  p_foreign_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != SEL) |=> $stable(cfg_q));

  // R2: a matching write is taken as written
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cfg_q == $past(wr_data[CFG_BITS-1:0])));

endmodule

// File: rtl/hib_fsm.sv
module hib_fsm
  import hib_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  hib_cfg_t   cfg_i,
  input  logic       done_i,
  output hib_state_e state_o,
  output logic       startup_req_o,
  output logic       reg_rst_o
);

  hib_state_e state_q, state_d;
  logic       startup_q;
  logic       regrst_q;
  logic       leaving;

  always_comb begin
    state_d = state_q;
    leaving = 1'b0;
    unique case (state_q)
      ST_ACTIVE: begin
        if (cfg_i.hib_req) state_d = ST_HIB;
      end
      ST_HIB: begin
        if (!cfg_i.hib_req) begin
          leaving = 1'b1;
          state_d = cfg_i.via_startup ? ST_STARTUP : ST_ACTIVE;
        end
      end
      ST_STARTUP: begin
        if (done_i) state_d = ST_ACTIVE;
      end
      default: state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_ACTIVE;
      startup_q <= 1'b0;
      regrst_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      startup_q <= (state_d == ST_STARTUP);
      regrst_q  <= leaving && !cfg_i.keep_regs;
    end
  end

  assign state_o       = state_q;
  assign startup_req_o = startup_q;
  assign reg_rst_o     = regrst_q;

  // R3: a pending request takes the controller into hibernate
  p_enter_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACTIVE && cfg_i.hib_req) |=> (state_q == ST_HIB));

  // R5: startup holds until done is seen
  p_startup_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STARTUP && !done_i) |=> (state_q == ST_STARTUP));

  // R5: request flag tracks the startup state
  p_req_match_r5: assert property (@(posedge clk) disable iff (rst)
    startup_q == (state_q == ST_STARTUP));

  // R6: the register reset lasts one cycle
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
    regrst_q |=> !regrst_q);

  // R6: the register reset only follows a hibernate exit
  p_pulse_source_r6: assert property (@(posedge clk) disable iff (rst)
    regrst_q |-> ($past(state_q) == ST_HIB && state_q != ST_HIB));

  // R11: done is ignored outside startup
  p_done_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACTIVE && !cfg_i.hib_req && done_i) |=> (state_q == ST_ACTIVE));

endmodule

// File: rtl/hib_pin_mux.sv
module hib_pin_mux
  import hib_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  hib_state_e state_i,
  input  hib_cfg_t   cfg_i,
  input  logic       rst_n_i,
  input  logic       irq_n_i,
  input  logic       memrst_n_i,
  output logic       rst_n_o,
  output logic       irq_n_o,
  output logic       memrst_n_o
);

  logic in_hib;
  logic rst_q, irq_q, memrst_q;

  assign in_hib = (state_i == ST_HIB);

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_q    <= 1'b1;
      irq_q    <= 1'b1;
      memrst_q <= 1'b1;
    end else if (in_hib) begin
      rst_q    <= cfg_i.rst_level;
      irq_q    <= cfg_i.irq_quiet | irq_n_i;
      memrst_q <= cfg_i.memrst_level;
    end else begin
      rst_q    <= rst_n_i;
      irq_q    <= irq_n_i;
      memrst_q <= memrst_n_i;
    end
  end

  assign rst_n_o    = rst_q;
  assign irq_n_o    = irq_q;
  assign memrst_n_o = memrst_q;

  // R7: reset pin held at its programmed level
  p_rst_pin_r7: assert property (@(posedge clk) disable iff (rst)
    in_hib |=> (rst_q == $past(cfg_i.rst_level)));

  // R8: quiet interrupt shows no request
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (in_hib && cfg_i.irq_quiet) |=> irq_q);

  // R9: memory reset pin held at its programmed level
  p_memrst_pin_r9: assert property (@(posedge clk) disable iff (rst)
    in_hib |=> (memrst_q == $past(cfg_i.memrst_level)));

  // R10: pins pass through outside hibernate
  p_pass_r10: assert property (@(posedge clk) disable iff (rst)
    !in_hib |=> ({rst_q, irq_q, memrst_q} == $past({rst_n_i, irq_n_i, memrst_n_i})));

endmodule

// File: rtl/hib_ctrl.sv
module hib_ctrl
  import hib_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int CFG_ADDR = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              startup_done,
  input  logic              rst_n_in,
  input  logic              irq_n_in,
  input  logic              memrst_n_in,
  output logic [1:0]        state,
  output logic              startup_req,
  output logic              reg_rst_pulse,
  output logic              rst_n_out,
  output logic              irq_n_out,
  output logic              memrst_n_out
);

  hib_cfg_t   cfg;
  hib_state_e st;

  hib_cfg_regs #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CFG_ADDR(CFG_ADDR)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .cfg_o  (cfg)
  );

  hib_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .cfg_i        (cfg),
    .done_i       (startup_done),
    .state_o      (st),
    .startup_req_o(startup_req),
    .reg_rst_o    (reg_rst_pulse)
  );

  hib_pin_mux u_pins (
    .clk       (clk),
    .rst       (rst),
    .state_i   (st),
    .cfg_i     (cfg),
    .rst_n_i   (rst_n_in),
    .irq_n_i   (irq_n_in),
    .memrst_n_i(memrst_n_in),
    .rst_n_o   (rst_n_out),
    .irq_n_o   (irq_n_out),
    .memrst_n_o(memrst_n_out)
  );

  assign state = st;

  initial begin
    if (DATA_W < CFG_BITS) $error("DATA_W too narrow for control word");
  end

endmodule

// File: tb/tb_hib_ctrl.sv
module tb_hib_ctrl;

  localparam int AW = 3;
  localparam int DW = 8;
  localparam int CA = 3;

  logic clk = 0;
  logic rst = 1;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic startup_done = 0;
  logic rst_n_in = 1, irq_n_in = 1, memrst_n_in = 1;
  logic [1:0] state;
  logic startup_req, reg_rst_pulse, rst_n_out, irq_n_out, memrst_n_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hib_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CFG_ADDR(CA)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .startup_done(startup_done), .rst_n_in(rst_n_in), .irq_n_in(irq_n_in),
    .memrst_n_in(memrst_n_in), .state(state), .startup_req(startup_req),
    .reg_rst_pulse(reg_rst_pulse), .rst_n_out(rst_n_out), .irq_n_out(irq_n_out),
    .memrst_n_out(memrst_n_out)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    tick();
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    check("R1 state", state, 0);
    check("R1 startup_req", startup_req, 0);
    check("R1 reg_rst_pulse", reg_rst_pulse, 0);
    check("R1 rst_n_out", rst_n_out, 1);
    check("R1 irq_n_out", irq_n_out, 1);
    check("R1 memrst_n_out", memrst_n_out, 1);

    // R2: writes to foreign addresses ignored
    for (int a = 0; a < (1 << AW); a++) begin
      if (a != CA) begin
        wr(a[AW-1:0], 8'h01);
        tick(); tick();
        check("R2 foreign addr", state, 0);
      end
    end

    // R10: pass-through outside hibernate, all input patterns
    for (int p = 0; p < 8; p++) begin
      tick();
      {memrst_n_in, irq_n_in, rst_n_in} = p[2:0];
      tick();
      check("R10 passthrough", {memrst_n_out, irq_n_out, rst_n_out}, p);
    end

    // R11: done ignored while active
    tick(); startup_done = 1; tick(); startup_done = 0;
    check("R11 done in active", state, 0);

    // Sweep all mode combinations
    for (int m = 0; m < 32; m++) begin
      automatic logic via  = m[0];
      automatic logic keep = m[1];
      automatic logic rlv  = m[2];
      automatic logic iq   = m[3];
      automatic logic mlv  = m[4];
      automatic logic [DW-1:0] word = DW'({mlv, iq, rlv, keep, via, 1'b1});
      rst_n_in = 0; irq_n_in = 0; memrst_n_in = 0;
      wr(CA[AW-1:0], word);
      tick();
      check("R3 enter hib", state, 1);
      check("R6 no pulse on entry", reg_rst_pulse, 0);
      tick();
      check("R7 rst pin", rst_n_out, rlv);
      check("R9 memrst pin", memrst_n_out, mlv);
      check("R8 irq pin low in", irq_n_out, iq ? 1 : 0);
      rst_n_in = 1; irq_n_in = 1; memrst_n_in = 1;
      startup_done = 1;
      tick();
      startup_done = 0;
      check("R11 done in hib", state, 1);
      check("R7 rst pin held", rst_n_out, rlv);
      check("R9 memrst pin held", memrst_n_out, mlv);
      check("R8 irq pin high in", irq_n_out, 1);
      // exit
      wr(CA[AW-1:0], word & ~DW'(1));
      tick();
      check("R4/R5 exit state", state, via ? 2 : 0);
      check("R6 pulse", reg_rst_pulse, keep ? 0 : 1);
      check("R5 startup_req", startup_req, via);
      tick();
      check("R6 pulse width", reg_rst_pulse, 0);
      check("R10 rst after exit", rst_n_out, 1);
      check("R10 memrst after exit", memrst_n_out, 1);
      if (via) begin
        if (m == 1) begin
          // R11: request loaded during startup waits for active
          wr(CA[AW-1:0], word);
        end
        repeat (3) tick();
        check("R5 startup hold", state, 2);
        check("R5 startup_req hold", startup_req, 1);
        startup_done = 1;
        tick();
        startup_done = 0;
        check("R5 done to active", state, 0);
        check("R5 startup_req drop", startup_req, 0);
        if (m == 1) begin
          tick();
          check("R11 deferred hib", state, 1);
          wr(CA[AW-1:0], word & ~DW'(1));
          tick();
          check("R11 exit again", state, 2);
          startup_done = 1; tick(); startup_done = 0;
          check("R11 back active", state, 0);
        end
      end
      tick();
    end

    // R1: reset returns request to 0
    wr(CA[AW-1:0], 8'h01);
    tick(); tick();
    check("R3 hib before reset", state, 1);
    rst = 1; tick(); rst = 0;
    repeat (3) tick();
    check("R1 request cleared by reset", state, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule